// File: doc/BRIEF.md
# Keyed configuration index/data port

This block is a byte-wide configuration register interface reached through two I/O locations. A one-bit address picks the port. Address 0 is the index port and address 1 is the data port. After reset the interface is locked. In that state a host can do nothing except feed bytes to the index port, which go to a key matcher. When the host writes the right key sequence, the interface unlocks. The host then writes a register number to the index port and reads or writes that register through the data port. An exit action locks the interface again.

Register numbers below 0x30 are global and shared by every logical device. The global set holds the device-select register, two read-only chip identity bytes and general read/write storage. Register numbers from 0x30 upward are banked. Each logical device keeps its own copy of those registers: an enable register, two 16-bit base addresses, an interrupt number and a DMA channel. The device-select register picks which bank those register numbers refer to.

A parameter selects one of two key schemes. The short scheme uses a two-byte key and exits on a fixed index-port byte. The long scheme uses a four-byte key whose last byte depends on the base-address choice, and exits on a data write to a global register.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked. While locked, every read returns 0xFF on either port, and data-port writes change no register.
- R2: With LONG_KEY=0, two consecutive index-port writes of 0x87 unlock the port. Bytes used to unlock do not become the selected index.
- R3: A key byte that does not match sends the matcher back to the start. If that byte equals the first key byte, it counts as step one of a new match.
- R4: With LONG_KEY=0, writing 0xAA to the index port while unlocked locks the port again. The selected index is left unchanged and all register contents are kept.
- R5: With LONG_KEY=1, the key is 0x87, 0x01, 0x55, then 0x55 when HI_BASE=0 or 0xAA when HI_BASE=1. Exit is a data write of 0x02 to register 0x02. In this mode an index write of 0xAA only selects register 0xAA.
- R6: Register 0x07 is the device select. It reads back what was written and resets to 0.
- R7: Registers 0x20 and 0x21 read the parameters ID_HI and ID_LO. Registers 0x00–0x06 read 0x00. Writes to all of these are dropped.
- R8: Registers 0x08–0x2F, other than 0x20 and 0x21, are global read/write bytes. They reset to 0 and read the same value whatever device is selected.
- R9: In each device bank, registers 0x30, 0x60, 0x61, 0x62, 0x63, 0x70 and 0x74 are independent read/write bytes. A write reaches only the bank of the selected device.
- R10: Every bank's enable register 0x30 resets to 0. Its bits can be set and cleared individually by read-modify-write.
- R11: Banked register numbers not listed in R9 read 0x00 and ignore writes. A selected device number of NUM_DEV or more reads 0x00 and ignores writes for all registers from 0x30 up.
- R12: Read data appears on rdata one clock after the rd_en cycle and holds until the next read. While unlocked, an index-port read returns the selected index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 1 | Port select: 0 selects the index port, 1 selects the data port |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| rdata | output | 8 | Registered read data |

## Verification
A wrong key-matcher state shows up on the very next read: the port returns 0xFF where register contents were expected, or register contents where 0xFF was expected. This can happen only after a full key sequence or an exit action. A wrong device select or a bank write that lands in the wrong bank stays hidden until that bank is read. For that reason every bank is written with distinct values and then read back under each selection. Global storage corruption appears on the first read of the affected register, one clock after the strobe. The bench's per-cycle model comparison finds any rdata mismatch within that clock.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;

    localparam logic [7:0] IDX_EXIT    = 8'h02;
    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_SCR_LO  = 8'h08;
    localparam logic [7:0] IDX_ID_HI   = 8'h20;
    localparam logic [7:0] IDX_ID_LO   = 8'h21;
    localparam logic [7:0] IDX_BANK_LO = 8'h30;
    localparam logic [7:0] EXIT_VAL    = 8'h02;
    localparam logic [7:0] EXIT_KEY    = 8'hAA;
    localparam logic [7:0] LOCKED_RD   = 8'hFF;

    localparam int NUM_SCR    = int'(IDX_BANK_LO) - int'(IDX_SCR_LO);
    localparam int BANK_SLOTS = 7;
    localparam logic [2:0] NO_SLOT = 3'd7;

    // Byte expected at a given step of the unlock sequence.
    function automatic logic [7:0] key_byte(input bit long_key, input bit hi_base,
                                            input logic [1:0] step);
        logic [7:0] b;
        if (!long_key) begin
            b = 8'h87;
        end else begin
            case (step)
                2'd0:    b = 8'h87;
                2'd1:    b = 8'h01;
                2'd2:    b = 8'h55;
                default: b = hi_base ? 8'hAA : 8'h55;
            endcase
        end
        return b;
    endfunction

    function automatic logic [1:0] key_last(input bit long_key);
        return long_key ? 2'd3 : 2'd1;
    endfunction

    // Storage slot of a banked register, NO_SLOT when not implemented.
    function automatic logic [2:0] bank_slot(input logic [7:0] idx);
        logic [2:0] s;
        case (idx)
            8'h30:   s = 3'd0;
            8'h60:   s = 3'd1;
            8'h61:   s = 3'd2;
            8'h62:   s = 3'd3;
            8'h63:   s = 3'd4;
            8'h70:   s = 3'd5;
            8'h74:   s = 3'd6;
            default: s = NO_SLOT;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/keyed_cfg_keymatch.sv
module keyed_cfg_keymatch
    import keyed_cfg_pkg::*;
#(
    parameter bit LONG_KEY = 1'b0,
    parameter bit HI_BASE  = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wbyte,
    input  logic       exit_req,
    output logic       unlocked
);

    localparam logic [1:0] LAST_STEP = key_last(LONG_KEY);
    localparam logic [7:0] FIRST_KEY = key_byte(LONG_KEY, HI_BASE, 2'd0);

    typedef struct packed {
        logic       open;
        logic [1:0] step;
    } km_state_t;

    km_state_t km_d, km_q;

    always_comb begin
        km_d = km_q;
        if (!km_q.open) begin
            if (idx_wr) begin
                if (wbyte == key_byte(LONG_KEY, HI_BASE, km_q.step)) begin
                    if (km_q.step == LAST_STEP) begin
                        km_d.open = 1'b1;
                        km_d.step = 2'd0;
                    end else begin
                        km_d.step = km_q.step + 2'd1;
                    end
                end else begin
                    km_d.step = (wbyte == FIRST_KEY) ? 2'd1 : 2'd0;
                end
            end
        end else if (exit_req) begin
            km_d.open = 1'b0;
            km_d.step = 2'd0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            km_q <= '0;
        end else begin
            km_q <= km_d;
        end
    end

    assign unlocked = km_q.open;

endmodule

// File: rtl/keyed_cfg_global.sv
module keyed_cfg_global
    import keyed_cfg_pkg::*;
#(
    parameter logic [7:0] ID_HI = 8'hC5,
    parameter logic [7:0] ID_LO = 8'h21
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] rd_val,
    output logic [7:0] ldn
);

    typedef struct packed {
        logic [7:0]               ldn;
        logic [NUM_SCR-1:0][7:0]  scr;
    } glob_state_t;

    glob_state_t gl_d, gl_q;

    logic [7:0] scr_off;
    logic       scr_hit;

    always_comb begin
        scr_off = idx - IDX_SCR_LO;
        scr_hit = (idx >= IDX_SCR_LO) && (idx < IDX_BANK_LO)
                  && (idx != IDX_ID_HI) && (idx != IDX_ID_LO);
    end

    always_comb begin
        gl_d = gl_q;
        if (wr) begin
            if (idx == IDX_LDN) begin
                gl_d.ldn = wdata;
            end else if (scr_hit) begin
                gl_d.scr[scr_off[5:0]] = wdata;
            end
        end
    end

    always_comb begin
        if (idx == IDX_LDN) begin
            rd_val = gl_q.ldn;
        end else if (idx == IDX_ID_HI) begin
            rd_val = ID_HI;
        end else if (idx == IDX_ID_LO) begin
            rd_val = ID_LO;
        end else if (scr_hit) begin
            rd_val = gl_q.scr[scr_off[5:0]];
        end else begin
            rd_val = 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gl_q <= '0;
        end else begin
            gl_q <= gl_d;
        end
    end

    assign ldn = gl_q.ldn;

endmodule

// File: rtl/keyed_cfg_bank.sv
module keyed_cfg_bank
    import keyed_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] rd_val
);

    typedef struct packed {
        logic [BANK_SLOTS-1:0][7:0] slot;
    } bank_state_t;

    bank_state_t bk_d, bk_q;
    logic [2:0]  sel;

    always_comb begin
        sel  = bank_slot(idx);
        bk_d = bk_q;
        if (wr && (sel != NO_SLOT)) begin
            bk_d.slot[sel] = wdata;
        end
    end

    always_comb begin
        if (sel != NO_SLOT) begin
            rd_val = bk_q.slot[sel];
        end else begin
            rd_val = 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
    import keyed_cfg_pkg::*;
#(
    parameter bit         LONG_KEY = 1'b0,
    parameter bit         HI_BASE  = 1'b0,
    parameter int         NUM_DEV  = 4,
    parameter logic [7:0] ID_HI    = 8'hC5,
    parameter logic [7:0] ID_LO    = 8'h21
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       rd_en,
    output logic [7:0] rdata
);

    localparam logic [7:0] DEV_LIMIT = 8'(NUM_DEV);

    typedef struct packed {
        logic [7:0] index;
        logic [7:0] rdata;
    } port_state_t;

    port_state_t pt_d, pt_q;

    logic             unlocked;
    logic [7:0]       ldn_sel;
    logic [7:0]       glob_rd;
    logic [7:0]       bank_rd [NUM_DEV];
    logic [NUM_DEV-1:0] bank_wr;
    logic             idx_wr;
    logic             dat_wr;
    logic             exit_req;
    logic             in_bank;
    logic             dev_hit;
    logic [7:0]       bank_val;
    logic [7:0]       data_val;

    always_comb begin
        idx_wr  = wr_en && !addr;
        dat_wr  = wr_en && addr && unlocked;
        in_bank = pt_q.index >= IDX_BANK_LO;
        dev_hit = ldn_sel < DEV_LIMIT;
        if (LONG_KEY) begin
            exit_req = dat_wr && (pt_q.index == IDX_EXIT) && (wdata == EXIT_VAL);
        end else begin
            exit_req = unlocked && idx_wr && (wdata == EXIT_KEY);
        end
    end

    keyed_cfg_keymatch #(
        .LONG_KEY (LONG_KEY),
        .HI_BASE  (HI_BASE)
    ) u_keymatch (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wbyte    (wdata),
        .exit_req (exit_req),
        .unlocked (unlocked)
    );

    keyed_cfg_global #(
        .ID_HI (ID_HI),
        .ID_LO (ID_LO)
    ) u_global (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (dat_wr && !in_bank),
        .idx    (pt_q.index),
        .wdata  (wdata),
        .rd_val (glob_rd),
        .ldn    (ldn_sel)
    );

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
        assign bank_wr[g] = dat_wr && in_bank && (ldn_sel == 8'(g));

        keyed_cfg_bank u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (bank_wr[g]),
            .idx    (pt_q.index),
            .wdata  (wdata),
            .rd_val (bank_rd[g])
        );
    end

    always_comb begin
        bank_val = 8'h00;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (ldn_sel == 8'(i)) begin
                bank_val = bank_rd[i];
            end
        end
        if (!unlocked) begin
            data_val = LOCKED_RD;
        end else if (!in_bank) begin
            data_val = glob_rd;
        end else if (dev_hit) begin
            data_val = bank_val;
        end else begin
            data_val = 8'h00;
        end
    end

    always_comb begin
        pt_d = pt_q;
        if (idx_wr && unlocked && !(exit_req && !LONG_KEY)) begin
            pt_d.index = wdata;
        end
        if (rd_en) begin
            if (addr) begin
                pt_d.rdata = data_val;
            end else begin
                pt_d.rdata = unlocked ? pt_q.index : LOCKED_RD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pt_q.index <= 8'h00;
            pt_q.rdata <= LOCKED_RD;
        end else begin
            pt_q <= pt_d;
        end
    end

    assign rdata = pt_q.rdata;

endmodule

// File: rtl/keyed_cfg_chk.sv
module keyed_cfg_chk #(
    parameter bit LONG_KEY = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       unlocked,
    input logic [7:0] ldn_sel
);

    a_r1_locked_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !unlocked) |=> (rdata == 8'hFF))
        else $error("R1 locked read did not return 0xFF");

    a_r2_unlock_by_index_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(wr_en && !addr))
        else $error("R2 unlock without index write");

    a_r4_short_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (!LONG_KEY && unlocked && wr_en && !addr && wdata == 8'hAA) |=> !unlocked)
        else $error("R4 exit byte did not lock");

    a_r5_long_index_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
        (LONG_KEY && unlocked && wr_en && !addr) |=> unlocked)
        else $error("R5 index write locked in long mode");

    a_r6_ldn_stable_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && wr_en && addr) |=> $stable(ldn_sel))
        else $error("R6 device select changed while locked");

    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata))
        else $error("R12 rdata changed without read");

endmodule

bind keyed_cfg_port keyed_cfg_chk #(.LONG_KEY(LONG_KEY)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .unlocked (unlocked),
    .ldn_sel  (ldn_sel)
);

// File: tb/keyed_cfg_port_tb.sv
module keyed_cfg_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NDEV = 4;
    localparam logic [7:0] IDH = 8'hC5;
    localparam logic [7:0] IDL = 8'h21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic a_addr = 1'b0, a_wr = 1'b0, a_rd = 1'b0;
    logic [7:0] a_wdata = 8'h00;
    logic [7:0] a_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    bit cmp_on = 1'b0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_cfg_port #(.LONG_KEY(1'b0), .HI_BASE(1'b0), .NUM_DEV(NDEV),
                     .ID_HI(IDH), .ID_LO(IDL)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rd_en(rd_en), .rdata(rdata));

    keyed_cfg_port #(.LONG_KEY(1'b1), .HI_BASE(1'b1), .NUM_DEV(NDEV),
                     .ID_HI(IDH), .ID_LO(IDL)) u_alt (
        .clk(clk), .rst_n(rst_n), .addr(a_addr), .wr_en(a_wr),
        .wdata(a_wdata), .rd_en(a_rd), .rdata(a_rdata));

    // ---------------- behavioural reference model for u_dut ----------------
    bit m_unl;
    int m_step;
    int m_index;
    int m_ldn;
    int m_rdata;
    int m_glob [256];
    int m_bank [NDEV][256];
    int key_q [$] = '{8'h87, 8'h87};

    function automatic bit m_impl(input int idx);
        return idx == 8'h30 || idx == 8'h60 || idx == 8'h61 || idx == 8'h62 ||
               idx == 8'h63 || idx == 8'h70 || idx == 8'h74;
    endfunction

    function automatic int m_data_read();
        if (!m_unl) return 8'hFF;
        if (m_index < 8'h30) begin
            if (m_index == 8'h07) return m_ldn;
            if (m_index == 8'h20) return IDH;
            if (m_index == 8'h21) return IDL;
            if (m_index < 8'h08) return 0;
            return m_glob[m_index];
        end
        if (m_ldn < NDEV && m_impl(m_index)) return m_bank[m_ldn][m_index];
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_unl = 1'b0; m_step = 0; m_index = 0; m_ldn = 0; m_rdata = 8'hFF;
            foreach (m_glob[i]) m_glob[i] = 0;
            foreach (m_bank[d, i]) m_bank[d][i] = 0;
        end else begin
            if (rd_en) m_rdata = addr ? m_data_read() : (m_unl ? m_index : 8'hFF);
            if (wr_en && !addr) begin
                if (!m_unl) begin
                    if (int'(wdata) == key_q[m_step]) begin
                        if (m_step == key_q.size() - 1) begin m_unl = 1'b1; m_step = 0; end
                        else m_step++;
                    end else begin
                        m_step = (int'(wdata) == key_q[0]) ? 1 : 0;
                    end
                end else if (wdata == 8'hAA) begin
                    m_unl = 1'b0;
                end else begin
                    m_index = wdata;
                end
            end else if (wr_en && addr && m_unl) begin
                if (m_index < 8'h30) begin
                    if (m_index == 8'h07) m_ldn = wdata;
                    else if (m_index >= 8'h08 && m_index != 8'h20 && m_index != 8'h21)
                        m_glob[m_index] = wdata;
                end else if (m_ldn < NDEV && m_impl(m_index)) begin
                    m_bank[m_ldn][m_index] = wdata;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            total++;
            if (rdata !== 8'(m_rdata)) begin
                bad++;
                $display("FAIL %s model compare: actual=%02h expected=%02h", cur_req, rdata, 8'(m_rdata));
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic put(input bit alt, input bit a, input logic [7:0] b);
        @(negedge clk);
        if (alt) begin a_addr = a; a_wr = 1'b1; a_wdata = b; end
        else     begin addr = a;   wr_en = 1'b1; wdata = b;  end
        @(negedge clk);
        a_wr = 1'b0; wr_en = 1'b0;
    endtask

    task automatic get(input bit alt, input bit a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        if (alt) begin a_addr = a; a_rd = 1'b1; end
        else     begin addr = a;   rd_en = 1'b1; end
        @(negedge clk);
        a_rd = 1'b0; rd_en = 1'b0;
        chk(tag, alt ? a_rdata : rdata, exp);
    endtask

    task automatic reg_wr(input bit alt, input logic [7:0] idx, input logic [7:0] v);
        put(alt, 1'b0, idx);
        put(alt, 1'b1, v);
    endtask

    task automatic reg_rd(input bit alt, input logic [7:0] idx, input logic [7:0] exp, input string tag);
        put(alt, 1'b0, idx);
        get(alt, 1'b1, exp, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        cur_req = "R1";
        chk("R1 reset rdata", rdata, 8'hFF);
        get(0, 1'b1, 8'hFF, "R1 locked data read");
        get(0, 1'b0, 8'hFF, "R1 locked index read");
        put(0, 1'b1, 8'h55);

        cur_req = "R3";
        put(0, 1'b0, 8'h87);
        put(0, 1'b0, 8'h12);
        put(0, 1'b0, 8'h87);
        get(0, 1'b1, 8'hFF, "R3 wrong byte reset matcher");
        cur_req = "R2";
        put(0, 1'b0, 8'h87);
        get(0, 1'b0, 8'h00, "R2 unlocked, key not taken as index");

        cur_req = "R6";
        reg_rd(0, 8'h07, 8'h00, "R6 device select reset");

        cur_req = "R7";
        reg_rd(0, 8'h20, IDH, "R7 id high");
        put(0, 1'b1, 8'h00);
        get(0, 1'b1, IDH, "R7 id high write dropped");
        reg_rd(0, 8'h21, IDL, "R7 id low");
        reg_wr(0, 8'h03, 8'hFF);
        get(0, 1'b1, 8'h00, "R7 low register write dropped");

        cur_req = "R8";
        reg_wr(0, 8'h10, 8'h5A);
        reg_rd(0, 8'h10, 8'h5A, "R8 global storage");
        reg_wr(0, 8'h2F, 8'hC3);

        cur_req = "R9";
        for (int d = 0; d < NDEV; d++) begin
            reg_wr(0, 8'h07, 8'(d));
            reg_rd(0, 8'h30, 8'h00, "R10 enable reset");
            reg_wr(0, 8'h60, 8'(8'h10 + d));
            reg_wr(0, 8'h63, 8'(8'hA0 + d));
            reg_wr(0, 8'h30, 8'(1 << d));
            reg_wr(0, 8'h74, 8'(d + 3));
        end
        for (int d = NDEV - 1; d >= 0; d--) begin
            reg_wr(0, 8'h07, 8'(d));
            reg_rd(0, 8'h60, 8'(8'h10 + d), "R9 bank base high");
            reg_rd(0, 8'h63, 8'(8'hA0 + d), "R9 bank base2 low");
            reg_rd(0, 8'h74, 8'(d + 3), "R9 bank dma");
            reg_rd(0, 8'h10, 8'h5A, "R8 global seen from every device");
            reg_rd(0, 8'h2F, 8'hC3, "R8 top global register");
        end

        cur_req = "R10";
        reg_wr(0, 8'h07, 8'd2);
        reg_rd(0, 8'h30, 8'h04, "R10 enable before set");
        put(0, 1'b1, 8'h05);
        get(0, 1'b1, 8'h05, "R10 set bit 0");
        put(0, 1'b1, 8'h01);
        get(0, 1'b1, 8'h01, "R10 clear bit 2");
        reg_wr(0, 8'h07, 8'd3);
        reg_rd(0, 8'h30, 8'h08, "R10 other bank untouched");

        cur_req = "R11";
        reg_wr(0, 8'h07, 8'd0);
        reg_wr(0, 8'h31, 8'h66);
        reg_rd(0, 8'h31, 8'h00, "R11 unimplemented banked register");
        reg_wr(0, 8'h07, 8'd5);
        reg_wr(0, 8'h60, 8'h77);
        reg_rd(0, 8'h60, 8'h00, "R11 device out of range");
        reg_wr(0, 8'h07, 8'd0);
        reg_rd(0, 8'h60, 8'h10, "R11 out-of-range write hit no bank");

        cur_req = "R12";
        get(0, 1'b0, 8'h60, "R12 index read");
        repeat (3) @(negedge clk);
        chk("R12 rdata held", rdata, 8'h60);

        cur_req = "R4";
        put(0, 1'b0, 8'h10);
        put(0, 1'b0, 8'hAA);
        get(0, 1'b1, 8'hFF, "R4 relocked");
        put(0, 1'b1, 8'h99);
        put(0, 1'b0, 8'h87);
        put(0, 1'b0, 8'h87);
        get(0, 1'b0, 8'h10, "R4 index kept over exit");
        get(0, 1'b1, 8'h5A, "R1 locked data write ignored");

        cur_req = "R5";
        put(1, 1'b0, 8'h87); put(1, 1'b0, 8'h01);
        put(1, 1'b0, 8'h55); put(1, 1'b0, 8'h55);
        get(1, 1'b1, 8'hFF, "R5 wrong last byte stays locked");
        put(1, 1'b0, 8'h87); put(1, 1'b0, 8'h01);
        put(1, 1'b0, 8'h55); put(1, 1'b0, 8'hAA);
        get(1, 1'b0, 8'h00, "R5 long key unlocks");
        put(1, 1'b0, 8'hAA);
        get(1, 1'b0, 8'hAA, "R5 0xAA only selects index");
        reg_rd(1, 8'h20, IDH, "R5 id readable in long mode");
        reg_wr(1, 8'h02, 8'h02);
        get(1, 1'b1, 8'hFF, "R5 exit by register write");

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule